// File: doc/BRIEF.md
# Shared-Drive Bus Isolation Controller

This block sits between a USB mass-storage bridge and a parallel disk interface that is shared with an external host processor. It decides, cycle by cycle, whether the bridge may drive the disk bus or must leave it in high impedance for the other processor. The decision draws on several signals: a permit line that the external processor can pull low, a host-power sense, the cable-attach and configured states of the USB side, a bus-suspend indication, and a latched safe-removal request.

The block drives three outputs. The first is a drive-enable: when it is low, the disk-side output buffers are tri-stated. The second is a status line back to the external processor. It is high only during normal operation, and it mirrors configuration-EEPROM read activity while the bridge is enumerating. The third is a 3-bit encoded operating mode, so that every condition can be observed.

Asynchronous inputs pass through a synchronizer before they are used. The drive-enable changes only while no disk strobe cycle is in flight, so a transfer is never cut off mid-strobe.

Top module: `drive_share_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with the cable detached, state_o is 5, ide_en_o is 0 and status_o is 0.
- R2: With attach_i low, state_o becomes 5 (unconnected), ide_en_o goes 0 and status_o goes 0. This holds whatever the values of permit_i, suspend_i and the other inputs.
- R3: When attached, with suspend_i high or a latched safe-removal request, state_o becomes 4 (suspended), ide_en_o goes 0 and status_o goes 0, for either value of permit_i.
- R4: When attached and not suspended, with permit_i low and host_pwr_i low, state_o becomes 0 (unpowered), ide_en_o goes 0 and status_o goes 0.
- R5: When attached and not suspended, with permit_i low and host_pwr_i high, state_o becomes 1 (forced detach), ide_en_o goes 0 and status_o goes 0.
- R6: When attached and not suspended, with permit_i high and cfg_done_i low, state_o becomes 2 (enumerating) and ide_en_o goes 0. status_o copies ee_act_i one rising edge after ee_act_i changes.
- R7: When attached and not suspended, with permit_i high and cfg_done_i high, state_o becomes 3 (normal), status_o goes 1 and ide_en_o goes 1.
- R8: A change on permit_i, suspend_i or host_pwr_i reaches state_o on the third rising edge after the change. ide_en_o follows state_o one edge later.
- R9: When the mode leaves normal while strobe_busy_i is high, ide_en_o stays 1. It falls on the first rising edge at which strobe_busy_i is low.
- R10: When the mode enters normal while strobe_busy_i is high, ide_en_o stays 0. It rises on the first rising edge at which strobe_busy_i is low.
- R11: A one-cycle pulse on safe_rm_i is held until a pulse on bus_reset_i clears it. If both pulses arrive in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| permit_i | input | 1 | Asynchronous permit line; low = host unpowered or external processor forcing detach |
| host_pwr_i | input | 1 | Asynchronous host power sense |
| suspend_i | input | 1 | Asynchronous USB suspend indication |
| attach_i | input | 1 | USB cable attached |
| cfg_done_i | input | 1 | Enumeration complete, device configured |
| ee_act_i | input | 1 | Configuration EEPROM read activity |
| safe_rm_i | input | 1 | Safe-removal request pulse |
| bus_reset_i | input | 1 | USB bus reset pulse, starting a fresh enumeration |
| strobe_busy_i | input | 1 | Disk strobe cycle in progress |
| ide_en_o | output | 1 | Disk interface drive enable; 0 = tri-stated |
| status_o | output | 1 | Status line to external processor |
| state_o | output | 3 | Encoded mode: 0 unpowered, 1 forced, 2 enumerating, 3 normal, 4 suspended, 5 unconnected |

## Verification
The bench asserts suspend while a strobe is held busy. A design that releases the bus without waiting would cut the transfer, and ide_en_o would drop early. It also returns to normal mode during a busy strobe, which catches an enable that rises mid-cycle. The latency test samples the edge just before the synchronized permit arrives and the edge at which it arrives. A design with a missing or extra stage shifts state_o by one edge. The safe-removal test checks that a single pulse stays in effect until a bus reset, and that a set and a clear in the same cycle keep the request. A design that cleared the request on its own, or let the clear win, would return to normal too early. Detaching while suspended confirms that the unconnected mode takes priority.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    MODE_UNPOWERED = 3'd0,
    MODE_FORCED    = 3'd1,
    MODE_ENUM      = 3'd2,
    MODE_NORMAL    = 3'd3,
    MODE_SUSPEND   = 3'd4,
    MODE_UNCONN    = 3'd5
  } mode_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsc_mode_decode.sv
module dsc_mode_decode
  import dsc_pkg::*;
(
  input  logic  attach_i,
  input  logic  suspend_i,
  input  logic  safe_rm_i,
  input  logic  permit_i,
  input  logic  host_pwr_i,
  input  logic  cfg_done_i,
  input  logic  ee_act_i,
  output mode_e mode_o,
  output logic  status_o
);
  // priority: detached > suspended/removed > permit low > configuring
  always_comb begin
    if (!attach_i)                  mode_o = MODE_UNCONN;
    else if (suspend_i || safe_rm_i) mode_o = MODE_SUSPEND;
    else if (!permit_i)             mode_o = host_pwr_i ? MODE_FORCED : MODE_UNPOWERED;
    else if (!cfg_done_i)           mode_o = MODE_ENUM;
    else                            mode_o = MODE_NORMAL;
  end

  always_comb begin
    unique case (mode_o)
      MODE_NORMAL: status_o = 1'b1;
      MODE_ENUM:   status_o = ee_act_i;
      default:     status_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsc_bus_gate.sv
module dsc_bus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic busy_i,
  output logic en_o
);
  logic en_q;

  // change only at an idle strobe boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (!busy_i) en_q <= want_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/drive_share_ctrl.sv
module drive_share_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              permit_i,
  input  logic              host_pwr_i,
  input  logic              suspend_i,
  input  logic              attach_i,
  input  logic              cfg_done_i,
  input  logic              ee_act_i,
  input  logic              safe_rm_i,
  input  logic              bus_reset_i,
  input  logic              strobe_busy_i,
  output logic              ide_en_o,
  output logic              status_o,
  output logic [MODE_W-1:0] state_o
);
  localparam int unsigned N_ASYNC = 3;

  logic [N_ASYNC-1:0] async_raw, async_syn;
  logic  permit_s, host_pwr_s, suspend_s;
  logic  removed_q;
  mode_e mode_d, mode_q;
  logic  status_d, status_q;

  assign async_raw = {suspend_i, host_pwr_i, permit_i};

  dsc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_syn)
  );

  assign {suspend_s, host_pwr_s, permit_s} = async_syn;

  // set beats clear when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          removed_q <= 1'b0;
    else if (safe_rm_i)   removed_q <= 1'b1;
    else if (bus_reset_i) removed_q <= 1'b0;
  end

  dsc_mode_decode u_decode (
    .attach_i   (attach_i),
    .suspend_i  (suspend_s),
    .safe_rm_i  (removed_q),
    .permit_i   (permit_s),
    .host_pwr_i (host_pwr_s),
    .cfg_done_i (cfg_done_i),
    .ee_act_i   (ee_act_i),
    .mode_o     (mode_d),
    .status_o   (status_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_UNCONN;
      status_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      status_q <= status_d;
    end
  end

  dsc_bus_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (mode_q == MODE_NORMAL),
    .busy_i (strobe_busy_i),
    .en_o   (ide_en_o)
  );

  assign status_o = status_q;
  assign state_o  = mode_q;
endmodule

// File: rtl/drive_share_ctrl_chk.sv
module drive_share_ctrl_chk
  import dsc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              attach_i,
  input logic              strobe_busy_i,
  input logic              ide_en_o,
  input logic              status_o,
  input logic [MODE_W-1:0] state_o
);
  a_r2_detached_unconn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(attach_i) |-> (state_o == MODE_UNCONN) && !status_o);

  a_r7_normal_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == MODE_NORMAL) |-> status_o);

  a_r6_status_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (state_o == MODE_NORMAL) || (state_o == MODE_ENUM));

  a_r9_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ide_en_o) |-> !$past(strobe_busy_i) && ($past(state_o) != MODE_NORMAL));

  a_r10_enable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ide_en_o) |-> !$past(strobe_busy_i) && ($past(state_o) == MODE_NORMAL));

  a_r1_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= MODE_UNCONN);
endmodule

bind drive_share_ctrl drive_share_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .attach_i      (attach_i),
  .strobe_busy_i (strobe_busy_i),
  .ide_en_o      (ide_en_o),
  .status_o      (status_o),
  .state_o       (state_o)
);

// File: tb/drive_share_ctrl_tb.sv
`timescale 1ns/1ps
module drive_share_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic permit = 0, host_pwr = 0, suspend = 0, attach = 0, cfg_done = 0;
  logic ee_act = 0, safe_rm = 0, bus_reset = 0, busy = 0;
  logic ide_en, status;
  logic [2:0] state;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  drive_share_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .permit_i(permit), .host_pwr_i(host_pwr),
    .suspend_i(suspend), .attach_i(attach), .cfg_done_i(cfg_done),
    .ee_act_i(ee_act), .safe_rm_i(safe_rm), .bus_reset_i(bus_reset),
    .strobe_busy_i(busy), .ide_en_o(ide_en), .status_o(status), .state_o(state)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, int st, int en, int stat);
    chk(req, "state", state, st);
    chk(req, "ide_en", ide_en, en);
    chk(req, "status", status, stat);
  endtask

  task automatic t_reset;
    chk_all("R1", 5, 0, 0);
    rst_n = 1'b1;
    tick(6);
    chk_all("R1", 5, 0, 0);
  endtask

  task automatic t_unconn;
    permit = 1; host_pwr = 1; cfg_done = 1;
    tick(6);
    chk_all("R2", 5, 0, 0);
  endtask

  task automatic t_normal;
    attach = 1;
    tick(6);
    chk_all("R7", 3, 1, 1);
  endtask

  task automatic t_enum;
    cfg_done = 0; ee_act = 1;
    tick(6);
    chk_all("R6", 2, 0, 1);
    ee_act = 0;
    tick(1);
    chk("R6", "status follows ee low", status, 0);
    ee_act = 1;
    tick(1);
    chk("R6", "status follows ee high", status, 1);
    ee_act = 0; cfg_done = 1;
    tick(6);
    chk_all("R7", 3, 1, 1);
  endtask

  task automatic t_permit_low;
    permit = 0; host_pwr = 0;
    tick(6);
    chk_all("R4", 0, 0, 0);
    host_pwr = 1;
    tick(6);
    chk_all("R5", 1, 0, 0);
  endtask

  task automatic t_latency;
    permit = 1;
    tick(2);
    chk("R8", "state before third edge", state, 1);
    tick(1);
    chk("R8", "state at third edge", state, 3);
    chk("R8", "enable lags state", ide_en, 0);
    tick(1);
    chk("R8", "enable one edge later", ide_en, 1);
  endtask

  task automatic t_suspend;
    suspend = 1; permit = 0;
    tick(6);
    chk_all("R3", 4, 0, 0);
    permit = 1;
    tick(6);
    chk_all("R3", 4, 0, 0);
    attach = 0;
    tick(2);
    chk_all("R2", 5, 0, 0);
    attach = 1; suspend = 0;
    tick(6);
    chk_all("R7", 3, 1, 1);
  endtask

  task automatic t_strobe;
    busy = 1; suspend = 1;
    tick(8);
    chk("R9", "mode suspended", state, 4);
    chk("R9", "bus held during strobe", ide_en, 1);
    busy = 0;
    tick(1);
    chk("R9", "released at idle", ide_en, 0);
    busy = 1; suspend = 0;
    tick(8);
    chk("R10", "mode normal", state, 3);
    chk("R10", "no enable during strobe", ide_en, 0);
    busy = 0;
    tick(1);
    chk("R10", "enabled at idle", ide_en, 1);
  endtask

  task automatic t_safe_rm;
    safe_rm = 1;
    tick(1);
    safe_rm = 0;
    tick(12);
    chk_all("R11", 4, 0, 0);
    bus_reset = 1;
    tick(1);
    bus_reset = 0;
    tick(4);
    chk_all("R11", 3, 1, 1);
    safe_rm = 1; bus_reset = 1;
    tick(1);
    safe_rm = 0; bus_reset = 0;
    tick(6);
    chk("R11", "set wins over clear", state, 4);
    bus_reset = 1;
    tick(1);
    bus_reset = 0;
    tick(4);
    chk("R11", "cleared by bus reset", state, 3);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    t_unconn();
    t_normal();
    t_enum();
    t_permit_low();
    t_latency();
    t_suspend();
    t_strobe();
    t_safe_rm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule